// File: doc/BRIEF.md
# SMBus Host Transaction Engine

This block is a byte-addressed register file with an SMBus host sequencer behind it. Software loads the target address, command code, outgoing data and byte count, and then writes a protocol code. That one write starts a complete transaction. The engine emits the phases for that protocol as a series of requests on an abstract byte-level bus port. When the transaction ends, it stores any received data in the data registers and posts a done flag together with a 5-bit result code in the status register.

The bus port works one phase at a time. The engine raises `bus_req` and holds an operation code, the byte to send and a "not-acknowledge this byte" flag. It keeps them steady until the bus side answers with a one-cycle `bus_done`. For a send, the answer carries the target's acknowledge. For a receive, it carries the byte read. Bit-level line timing is left to whatever sits on that port.

The engine can also add packet error checking, using a CRC-8 with polynomial 0x07. A stall watchdog with a programmable limit ends a transaction that makes no progress.

Top module: `smbus_xact_engine`

## Requirements
- R1: After reset every register reads 0x00, including status, and `bus_req` is low.
- R2: Register offsets: 0x00 protocol, 0x01 status (read-only, writes ignored), 0x02 target address (7-bit address in bits 7:1), 0x03 command, 0x04..0x23 data bytes, 0x24 byte count, 0x25 alarm address, 0x26..0x27 alarm data. All registers other than status read back what was written.
- R3: Writing a supported code to offset 0x00 while idle clears the done bit and starts a transaction. Bit 0 of the code selects read (1) or write (0). Bits 6:1 select the kind: 0x01 quick, 0x02 byte, 0x03 byte-data, 0x04 word, 0x05 block, 0x06 process call (code 0x0C) or block process call (code 0x0D), and 0x25 raw block (codes 0x4A/0x4B). Any other kind sets status to 0x99 with no bus activity.
- R4: Bus operation codes are 0 start, 1 send, 2 receive, 3 repeated start and 4 stop. `bus_req`, `bus_op` and `bus_wdata` hold steady until `bus_done`.
- R5: Write sequences are as follows. Quick sends the address byte `{addr[7:1], bit0}` and then stops. Byte-data write sends address+0, the command, one data byte from 0x04, and then stops.
- R6: Word read sends start, address+0 and the command, then a repeated start and address+1, then receives two bytes into 0x04 (low) and 0x05 (high). `bus_nack` is set only on the final byte received.
- R7: Block write sends a count of min(count,32) followed by that many data bytes. Block read receives a count, stores min(count,32) at 0x24, and then receives that many bytes. Raw block read sends and receives no count byte and reads min(0x24,32) bytes.
- R8: Process call (0x0C) sends the word in 0x04/0x05. After a repeated start, it reads a word back into the same two registers.
- R9: When bit 7 of the code is set and the kind is not quick, a CRC-8 is kept over every byte on the bus, address bytes included. The CRC uses polynomial 0x07, initial value 0 and MSB first. It is appended as the final byte on writes. On reads it is received as the final byte and compared, and a mismatch gives code 0x1F.
- R10: Completion sets status bit 7 with the result code in bits 4:0. Success is 0x00, so status reads 0x80.
- R11: A not-acknowledge on an address byte ends with a stop and code 0x10. A not-acknowledge on any later sent byte ends with a stop and code 0x11.
- R12: A protocol write while a transaction is running is ignored: the protocol register is unchanged and done stays 0. The status code reads 0x1A until the running transaction posts its own result.
- R13: If no `bus_done` arrives for more than `tmo_cycles` cycles, the engine issues a stop and ends with code 0x18. If the stalled phase is the stop itself, it ends directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tmo_cycles | input | TMO_W | Stall limit in cycles |
| bus_req | output | 1 | Phase request, held until bus_done |
| bus_op | output | 3 | Phase operation code |
| bus_wdata | output | 8 | Byte to send |
| bus_nack | output | 1 | Do not acknowledge the byte being received |
| bus_done | input | 1 | Phase complete, one cycle |
| bus_ack | input | 1 | Target acknowledged the sent byte |
| bus_rdata | input | 8 | Received byte, valid with bus_done |

## Verification
Register reads are combinational, so a value written at one edge can be read back in the next cycle. After the protocol write, the first start request appears on the port at the following edge. Each later phase is presented at the edge where the previous `bus_done` is seen. The done flag and the result code land at the edge that accepts the stop acknowledge. The bench therefore drives the bus responder and the register port at falling edges, samples a read one time unit later, and polls status until bit 7 rises before it compares the logged phases and the received data.

// File: rtl/smbus_xact_engine.sv
module smbus_xact_engine #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [5:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [TMO_W-1:0] tmo_cycles,
  output logic             bus_req,
  output logic [2:0]       bus_op,
  output logic [7:0]       bus_wdata,
  output logic             bus_nack,
  input  logic             bus_done,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata
);
  localparam int NREG = 40;
  localparam int MAXB = 32;
  localparam logic [5:0] O_ADDR = 6'd2, O_CMD = 6'd3, O_DATA = 6'd4, O_CNT = 6'd36;

  typedef enum logic [3:0] {IDLE, START, ADDR, CMD, WCNT, WDATA, WPEC,
                            RSTART, RADDR, RCNT, RDATA, RPEC, STOP} st_t;

  logic [7:0]       rf [NREG];
  logic [7:0]       stat;
  logic [4:0]       err;
  logic [5:0]       idx;
  logic [7:0]       crc;
  logic [TMO_W-1:0] tcnt;
  st_t              st;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  function automatic logic known(input logic [5:0] k);
    return (k >= 6'h01 && k <= 6'h06) || k == 6'h25;
  endfunction

  wire [7:0] prot   = rf[0];
  wire [5:0] kind   = prot[6:1];
  wire       rd     = prot[0];
  wire       k_q    = kind == 6'h01;
  wire       k_b    = kind == 6'h02;
  wire       k_bd   = kind == 6'h03;
  wire       k_w    = kind == 6'h04;
  wire       k_blk  = kind == 6'h05;
  wire       k_raw  = kind == 6'h25;
  wire       pc     = kind == 6'h06 && !rd;
  wire       bpc    = kind == 6'h06 && rd;
  wire       pec    = prot[7] && !k_q;
  wire [5:0] clen   = (rf[O_CNT] > 8'(MAXB)) ? 6'(MAXB) : rf[O_CNT][5:0];
  wire [5:0] wlen   = (k_bd && !rd) ? 6'd1 : ((k_w && !rd) || pc) ? 6'd2 :
                      (((k_blk || k_raw) && !rd) || bpc) ? clen : 6'd0;
  wire [5:0] rlen   = ((k_b || k_bd) && rd) ? 6'd1 : ((k_w && rd) || pc) ? 6'd2 : clen;
  wire       wcnt_p = (k_blk && !rd) || bpc;
  wire       rcnt_p = (k_blk && rd) || bpc;
  wire       rd_p   = ((k_b || k_bd || k_w || k_blk || k_raw) && rd) || pc || bpc;
  wire       dir0   = (k_q || k_b) && rd;
  wire [5:0] didx   = idx + O_DATA;
  wire       tmo    = tcnt >= tmo_cycles;
  wire [7:0] rclamp = (bus_rdata > 8'(MAXB)) ? 8'(MAXB) : bus_rdata;
  st_t after_wr;
  assign after_wr = rd_p ? RSTART : (pec ? WPEC : STOP);

  assign reg_rdata = (reg_addr == 6'd1) ? stat : (reg_addr < 6'(NREG)) ? rf[reg_addr] : 8'h00;
  assign bus_req   = st != IDLE;
  assign bus_nack  = (st == RDATA && idx == rlen - 6'd1 && !pec) || st == RPEC;

  always_comb begin
    case (st)
      START:              bus_op = 3'd0;
      RSTART:             bus_op = 3'd3;
      STOP:               bus_op = 3'd4;
      RCNT, RDATA, RPEC:  bus_op = 3'd2;
      default:            bus_op = 3'd1;
    endcase
    case (st)
      ADDR:    bus_wdata = {rf[O_ADDR][7:1], dir0};
      RADDR:   bus_wdata = {rf[O_ADDR][7:1], 1'b1};
      CMD:     bus_wdata = rf[O_CMD];
      WCNT:    bus_wdata = {2'b00, clen};
      WDATA:   bus_wdata = rf[didx];
      WPEC:    bus_wdata = crc;
      default: bus_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
      st <= IDLE; stat <= 8'h00; err <= 5'h00; idx <= 6'd0; crc <= 8'h00; tcnt <= '0;
    end else begin
      if (reg_we && reg_addr < 6'(NREG) && reg_addr != 6'd1 && !(reg_addr == 6'd0 && st != IDLE))
        rf[reg_addr] <= reg_wdata;
      if (reg_we && reg_addr == 6'd0 && st != IDLE)
        stat[4:0] <= 5'h1A;
      if (st == IDLE) begin
        if (reg_we && reg_addr == 6'd0) begin
          if (known(reg_wdata[6:1])) begin
            st <= START; stat <= 8'h00; err <= 5'h00; crc <= 8'h00; idx <= 6'd0; tcnt <= '0;
          end else
            stat <= 8'h99;
        end
      end else if (bus_done) begin
        tcnt <= '0;
        case (st)
          START:  st <= ADDR;
          ADDR: begin
            crc <= crc8(crc, bus_wdata);
            if (!bus_ack) begin err <= 5'h10; st <= STOP; end
            else if (k_q) st <= STOP;
            else if (k_b && rd) st <= RDATA;
            else st <= CMD;
          end
          CMD, WCNT: begin
            crc <= crc8(crc, bus_wdata);
            if (!bus_ack) begin err <= 5'h11; st <= STOP; end
            else if (st == CMD && wcnt_p) st <= WCNT;
            else st <= (wlen != 6'd0) ? WDATA : after_wr;
          end
          WDATA: begin
            crc <= crc8(crc, bus_wdata);
            if (!bus_ack) begin err <= 5'h11; st <= STOP; end
            else if (idx == wlen - 6'd1) begin idx <= 6'd0; st <= after_wr; end
            else idx <= idx + 6'd1;
          end
          WPEC: begin
            if (!bus_ack) err <= 5'h11;
            st <= STOP;
          end
          RSTART: st <= RADDR;
          RADDR: begin
            crc <= crc8(crc, bus_wdata);
            idx <= 6'd0;
            if (!bus_ack) begin err <= 5'h10; st <= STOP; end
            else if (rcnt_p) st <= RCNT;
            else st <= (rlen != 6'd0) ? RDATA : (pec ? RPEC : STOP);
          end
          RCNT: begin
            crc <= crc8(crc, bus_rdata);
            rf[O_CNT] <= rclamp;
            st <= (rclamp != 8'd0) ? RDATA : (pec ? RPEC : STOP);
          end
          RDATA: begin
            crc <= crc8(crc, bus_rdata);
            rf[didx] <= bus_rdata;
            if (idx == rlen - 6'd1) begin idx <= 6'd0; st <= pec ? RPEC : STOP; end
            else idx <= idx + 6'd1;
          end
          RPEC: begin
            if (bus_rdata != crc) err <= 5'h1F;
            st <= STOP;
          end
          default: begin
            stat <= {3'b100, err};
            st <= IDLE;
          end
        endcase
      end else if (tmo) begin
        tcnt <= '0;
        if (st == STOP) begin stat <= {3'b100, 5'h18}; st <= IDLE; end
        else begin err <= 5'h18; st <= STOP; end
      end else
        tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/smbus_xact_engine_chk.sv
module smbus_xact_engine_chk #(
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [5:0]       reg_addr,
  input logic             bus_req,
  input logic [2:0]       bus_op,
  input logic [7:0]       bus_wdata,
  input logic             bus_done,
  input logic [7:0]       stat,
  input logic [7:0]       prot,
  input logic [TMO_W-1:0] tcnt,
  input logic [TMO_W-1:0] tmo_cycles
);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7] |-> !bus_req);

  assert_op_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done && tcnt < tmo_cycles) |=> bus_req && $stable(bus_op) && $stable(bus_wdata));

  assert_busy_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && reg_we && reg_addr == 6'd0 && !(bus_op == 3'd4 && (bus_done || tcnt >= tmo_cycles)))
    |=> $stable(prot) && !stat[7] && stat[4:0] == 5'h1A);

  assert_stop_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == 3'd4 && bus_done) |=> stat[7] && !bus_req);

  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && reg_we && reg_addr == 6'd0) |=> (bus_req && !stat[7] && bus_op == 3'd0) || stat == 8'h99);
endmodule

bind smbus_xact_engine smbus_xact_engine_chk #(.TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_done(bus_done),
  .stat(stat), .prot(prot), .tcnt(tcnt), .tmo_cycles(tmo_cycles));

// File: tb/smbus_xact_engine_test.sv
module smbus_xact_engine_test;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [5:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [15:0] tmo_cycles = 16'd1000;
  logic bus_req, bus_nack, bus_done, bus_ack;
  logic [2:0] bus_op;
  logic [7:0] bus_wdata, bus_rdata;

  int n_cmp = 0, n_bad = 0;
  int lg_n = 0, rxi = 0, sendi = 0, nak_at = -1, delay = 0;
  bit stall = 0, seen_stop = 0;
  logic [2:0] lg_op [0:99];
  logic [7:0] lg_b  [0:99];
  logic       lg_nk [0:99];
  logic [7:0] rxq   [0:63];

  always #2 clk = ~clk;

  smbus_xact_engine uut (.*);

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  initial begin
    bus_done = 0; bus_ack = 0; bus_rdata = 0;
    forever begin
      @(negedge clk);
      if (bus_req && stall && bus_op == 3'd4) seen_stop = 1;
      if (bus_req && !stall) begin
        if (lg_n < 100) begin lg_op[lg_n] = bus_op; lg_b[lg_n] = bus_wdata; lg_nk[lg_n] = bus_nack; end
        lg_n++;
        bus_ack = 1;
        if (bus_op == 3'd1) begin if (sendi == nak_at) bus_ack = 0; sendi++; end
        if (bus_op == 3'd2) begin bus_rdata = rxq[rxi % 64]; rxi++; end
        repeat (delay) @(negedge clk);
        bus_done = 1;
        @(negedge clk);
        bus_done = 0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clr();
    lg_n = 0; rxi = 0; sendi = 0; nak_at = -1;
  endtask

  task automatic run(input logic [7:0] code, output logic [7:0] s);
    wr(6'd0, code);
    for (int i = 0; i < 3000; i++) begin
      rd(6'd1, s);
      if (s[7]) break;
    end
  endtask

  task automatic exp_op(input string req, input int i, input logic [2:0] op, input logic [7:0] b);
    check(req, {29'd0, lg_op[i]}, {29'd0, op});
    if (op == 3'd1) check(req, {24'd0, lg_b[i]}, {24'd0, b});
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(6'd1, v); check("R1 status", v, 8'h00);
    rd(6'd36, v); check("R1 count", v, 8'h00);
    check("R1 req", bus_req, 1'b0);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(6'd2, 8'h5A); wr(6'd35, 8'h77); wr(6'd37, 8'h3C); wr(6'd1, 8'hFF);
    rd(6'd2, v);  check("R2 addr", v, 8'h5A);
    rd(6'd35, v); check("R2 data31", v, 8'h77);
    rd(6'd37, v); check("R2 alarm", v, 8'h3C);
    rd(6'd1, v);  check("R2 status ro", v, 8'h00);
  endtask

  task automatic t_quick();
    logic [7:0] s;
    wr(6'd2, 8'hA0);
    clr(); run(8'h02, s);
    check("R10 quick status", s, 8'h80);
    check("R5 quick len", lg_n, 3);
    exp_op("R5 quick start", 0, 3'd0, 0); exp_op("R5 quick addr", 1, 3'd1, 8'hA0); exp_op("R5 quick stop", 2, 3'd4, 0);
    clr(); run(8'h83, s);
    check("R9 quick no pec", lg_n, 3);
    exp_op("R5 quick rd addr", 1, 3'd1, 8'hA1);
  endtask

  task automatic t_bytedata();
    logic [7:0] s;
    wr(6'd3, 8'h11); wr(6'd4, 8'h22);
    clr(); run(8'h06, s);
    check("R5 bd status", s, 8'h80);
    check("R5 bd len", lg_n, 5);
    exp_op("R5 bd addr", 1, 3'd1, 8'hA0); exp_op("R5 bd cmd", 2, 3'd1, 8'h11);
    exp_op("R5 bd data", 3, 3'd1, 8'h22); exp_op("R5 bd stop", 4, 3'd4, 0);
  endtask

  task automatic t_word_rd();
    logic [7:0] s, v;
    rxq[0] = 8'h34; rxq[1] = 8'h12;
    clr(); run(8'h09, s);
    check("R6 wr status", s, 8'h80);
    check("R6 wr len", lg_n, 8);
    exp_op("R6 rstart", 3, 3'd3, 0); exp_op("R6 raddr", 4, 3'd1, 8'hA1);
    exp_op("R6 recv", 5, 3'd2, 0);
    check("R6 ack first", lg_nk[5], 1'b0); check("R6 nack last", lg_nk[6], 1'b1);
    rd(6'd4, v); check("R6 low", v, 8'h34);
    rd(6'd5, v); check("R6 high", v, 8'h12);
  endtask

  task automatic t_block_wr_pec();
    logic [7:0] s, c;
    wr(6'd36, 8'd3); wr(6'd4, 8'hAA); wr(6'd5, 8'hBB); wr(6'd6, 8'hCC);
    c = crc8(crc8(crc8(crc8(crc8(crc8(8'h00, 8'hA0), 8'h11), 8'h03), 8'hAA), 8'hBB), 8'hCC);
    clr(); run(8'h8A, s);
    check("R7 bw status", s, 8'h80);
    check("R7 bw len", lg_n, 9);
    exp_op("R7 bw count", 3, 3'd1, 8'h03); exp_op("R7 bw last", 6, 3'd1, 8'hCC);
    exp_op("R9 bw pec", 7, 3'd1, c);
  endtask

  task automatic t_block_rd_pec();
    logic [7:0] s, v, c;
    c = crc8(crc8(crc8(crc8(crc8(crc8(8'h00, 8'hA0), 8'h11), 8'hA1), 8'h02), 8'h55), 8'h66);
    rxq[0] = 8'h02; rxq[1] = 8'h55; rxq[2] = 8'h66; rxq[3] = c;
    clr(); run(8'h8B, s);
    check("R9 br status", s, 8'h80);
    check("R7 br len", lg_n, 10);
    check("R9 nack on pec", lg_nk[8], 1'b1); check("R9 ack on data", lg_nk[7], 1'b0);
    rd(6'd36, v); check("R7 br count", v, 8'h02);
    rd(6'd5, v); check("R7 br data1", v, 8'h66);
    rxq[3] = c ^ 8'h01;
    clr(); run(8'h8B, s);
    check("R9 pec mismatch", s, 8'h9F);
  endtask

  task automatic t_block_clamp();
    logic [7:0] s, v;
    rxq[0] = 8'd40;
    for (int i = 1; i <= 32; i++) rxq[i] = 8'(i + 8'h40);
    clr(); run(8'h0B, s);
    check("R7 clamp status", s, 8'h80);
    rd(6'd36, v); check("R7 clamp count", v, 8'd32);
    check("R7 clamp len", lg_n, 39);
    rd(6'd35, v); check("R7 clamp last", v, 8'h60);
  endtask

  task automatic t_raw_rd();
    logic [7:0] s, v;
    wr(6'd36, 8'd2);
    rxq[0] = 8'h09; rxq[1] = 8'h08;
    clr(); run(8'h4B, s);
    check("R7 raw status", s, 8'h80);
    check("R7 raw len", lg_n, 8);
    exp_op("R7 raw recv", 5, 3'd2, 0);
    rd(6'd5, v); check("R7 raw data", v, 8'h08);
  endtask

  task automatic t_proc();
    logic [7:0] s, v;
    wr(6'd4, 8'h01); wr(6'd5, 8'h02);
    rxq[0] = 8'hCD; rxq[1] = 8'hAB;
    clr(); run(8'h0C, s);
    check("R8 status", s, 8'h80);
    check("R8 len", lg_n, 10);
    exp_op("R8 send lo", 3, 3'd1, 8'h01); exp_op("R8 send hi", 4, 3'd1, 8'h02);
    exp_op("R8 rstart", 5, 3'd3, 0);
    rd(6'd4, v); check("R8 rx lo", v, 8'hCD);
    rd(6'd5, v); check("R8 rx hi", v, 8'hAB);
  endtask

  task automatic t_nak();
    logic [7:0] s;
    clr(); nak_at = 0; run(8'h06, s);
    check("R11 addr nak", s, 8'h90);
    check("R11 addr nak len", lg_n, 3);
    clr(); nak_at = 2; run(8'h06, s);
    check("R11 data nak", s, 8'h91);
    check("R11 data nak len", lg_n, 5);
    exp_op("R11 stop", 4, 3'd4, 0);
    nak_at = -1;
  endtask

  task automatic t_busy();
    logic [7:0] s, v;
    clr(); delay = 20;
    wr(6'd0, 8'h06);
    wr(6'd0, 8'h0A);
    rd(6'd1, v); check("R12 busy code", v, 8'h1A);
    rd(6'd0, v); check("R12 prot kept", v, 8'h06);
    for (int i = 0; i < 3000; i++) begin rd(6'd1, s); if (s[7]) break; end
    check("R12 final", s, 8'h80);
    delay = 0;
  endtask

  task automatic t_timeout();
    logic [7:0] s;
    clr(); tmo_cycles = 16'd20; stall = 1; seen_stop = 0;
    run(8'h02, s);
    check("R13 status", s, 8'h98);
    check("R13 stop issued", seen_stop, 1'b1);
    check("R13 idle", bus_req, 1'b0);
    stall = 0; tmo_cycles = 16'd1000;
  endtask

  task automatic t_unsup();
    logic [7:0] s;
    clr(); run(8'h0E, s);
    check("R3 unsupported", s, 8'h99);
    check("R3 no bus", lg_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_regmap(); t_quick(); t_bytedata(); t_word_rd(); t_block_wr_pec();
    t_block_rd_pec(); t_block_clamp(); t_raw_rd(); t_proc(); t_nak(); t_busy();
    t_timeout(); t_unsup();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule